// File: doc/BRIEF.md
# Serial PCM Voice Port with Bit-Clock Generator

This block moves one 8-bit companded voice sample per frame in each direction over a 2.048 MHz serial PCM line. Serial input arrives on `pcmin` and serial output leaves on `pcmout`, both at the same time. A frame is marked by a one-bit-wide sync pulse. The sample takes the eight bit periods that follow that pulse, most significant bit first. The surrounding core exchanges samples through parallel byte ports. A received byte comes with a single-cycle valid strobe. A byte to transmit is offered with a valid/ready handshake and held until the next frame picks it up.

The port runs in one of two timing modes. In internal mode it derives the bit clock from a 98.304 MHz working clock by dividing by 48. It counts 256 bit clocks per frame, which gives an 8 kHz frame rate, and drives both timing signals out to an attached codec. In external mode it follows the bit clock and frame sync of a codec. These pass through a two-flop synchronizer and are edge-detected in the working-clock domain. The working clock frequency is a parameter. An instance built for any other frequency refuses internal mode, flags the refusal, and keeps running from the external timing.

Top module: `pcm_voice_port`

## Requirements
- R1: In internal mode `bclk_out` is high for 24 working-clock cycles and low for 24, and `clk_drive_en` is 1.
- R2: In internal mode `fs_out` rises once every 256 bit clocks and stays high for exactly one bit clock. It changes only together with a rising edge of `bclk_out`.
- R3: A sample is carried in the 8 bit periods right after the sync bit period, MSB first. `pcmout` changes only after a rising bit-clock edge. `pcmin` is captured at the falling edge.
- R4: After the eighth sample bit has been captured, `rx_data` holds the received byte and `rx_valid` is high for exactly one working-clock cycle.
- R5: A byte accepted on `tx_valid`&&`tx_ready` before a frame's sync is sent in that frame. If no new byte was accepted, the previous byte is sent again. After reset the byte sent is `TX_IDLE`, which is 8'hD5 by default.
- R6: `pcmout` is 0 in every bit period outside the 8 sample periods.
- R7: In external mode (`int_mode`=0) the port follows `bclk_in`/`fs_in`, and `clk_drive_en`, `bclk_out` and `fs_out` are 0.
- R8: When `WORK_KHZ` is not 98304, `int_mode`=1 sets `int_refused` to 1, keeps `clk_drive_en` and `bclk_out` at 0, and the port keeps working from `bclk_in`/`fs_in`.
- R9: During reset `bclk_out`, `fs_out`, `pcmout`, `rx_valid` and `clk_drive_en` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Working clock (98.304 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_mode | input | 1 | 1 requests internal timing generation, 0 follows external timing |
| bclk_in | input | 1 | Bit clock from an external codec |
| fs_in | input | 1 | Frame sync from an external codec |
| pcmin | input | 1 | Serial receive data |
| tx_data | input | SAMPLE_W | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Port accepts `tx_data` this cycle |
| rx_data | output | SAMPLE_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| pcmout | output | 1 | Serial transmit data |
| bclk_out | output | 1 | Generated bit clock |
| fs_out | output | 1 | Generated frame sync |
| clk_drive_en | output | 1 | Generated timing is being driven |
| int_refused | output | 1 | Internal mode requested but not allowed for this working clock |

## Verification
The serial path is exercised in external mode with byte pairs chosen to separate failure types. All-zero and all-one bytes expose a stuck line. Patterns with only the MSB or only the LSB set expose bit order and a one-slot misalignment against the sync. Alternating patterns expose shifts by one bit. A frame with no new transmit byte shows whether the held byte is repeated or the idle code is reused. Internal mode is run for whole frames with phase lengths and frame lengths measured, so that a wrong divider or frame count is told apart from a data fault. A second instance built for a 100 MHz working clock shows that refusal blocks the generator but not the data path.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

   // Working clock at which internal timing generation is allowed (kHz).
   localparam int unsigned REQ_WORK_KHZ = 98304;

   // One-cycle bit-clock edge events in the working-clock domain.
   typedef struct packed {
      logic rise;
      logic fall;
   } bit_edge_t;

   typedef enum logic {
      SRC_EXTERNAL = 1'b0,
      SRC_INTERNAL = 1'b1
   } clk_src_e;

endpackage

// File: rtl/pcm_clk_gen.sv
module pcm_clk_gen
   import pcm_port_pkg::*;
#(
   parameter int unsigned CLK_DIV    = 48,
   parameter int unsigned FRAME_BITS = 256
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   output logic      bclk,
   output logic      fs,
   output bit_edge_t edge_o
);
   localparam int unsigned HALF = CLK_DIV / 2;
   localparam int unsigned CW   = $clog2(CLK_DIV);
   localparam int unsigned SW   = $clog2(FRAME_BITS);

   if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("pcm_clk_gen: CLK_DIV must be even and at least 4");
   end
   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("pcm_clk_gen: FRAME_BITS must be at least 2");
   end

   logic [CW-1:0] div_q;
   logic [SW-1:0] slot_q;
   logic          wrap, mid, last_slot;

   assign wrap      = (div_q == CW'(CLK_DIV - 1));
   assign mid       = (div_q == CW'(HALF - 1));
   assign last_slot = (slot_q == SW'(FRAME_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         slot_q <= SW'(FRAME_BITS - 1);
         bclk   <= 1'b0;
         fs     <= 1'b0;
         edge_o <= '0;
      end else if (!run) begin
         div_q  <= '0;
         slot_q <= SW'(FRAME_BITS - 1);
         bclk   <= 1'b0;
         fs     <= 1'b0;
         edge_o <= '0;
      end else begin
         div_q       <= wrap ? '0 : div_q + 1'b1;
         edge_o.rise <= wrap;
         edge_o.fall <= mid;
         if (wrap) begin
            bclk   <= 1'b1;
            slot_q <= last_slot ? '0 : slot_q + 1'b1;
            fs     <= last_slot;
         end
         if (mid) begin
            bclk <= 1'b0;
         end
      end
   end

   // Checker state: cycles since the last bit-clock edge event.
   logic [CW-1:0] len_q;
   logic          armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q   <= '0;
         armed_q <= 1'b0;
      end else if (!run) begin
         len_q   <= '0;
         armed_q <= 1'b0;
      end else if (edge_o.rise || edge_o.fall) begin
         len_q   <= '0;
         armed_q <= 1'b1;
      end else begin
         len_q <= len_q + 1'b1;
      end
   end

   p_half_period_r1: assert property (@(posedge clk) disable iff (!rst_n || !run)
      (armed_q && (edge_o.rise || edge_o.fall)) |-> (len_q == CW'(HALF - 1)));

   p_fs_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n || !run)
      !$stable(fs) |-> edge_o.rise);

endmodule

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync
   import pcm_port_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bclk_in,
   input  logic      fs_in,
   input  logic      din,
   output bit_edge_t edge_o,
   output logic      fs_s,
   output logic      din_s
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcm_edge_sync: STAGES must be at least 2");
   end

   // Bit 2 = bit clock, bit 1 = frame sync, bit 0 = data.
   logic [2:0] chain_q [STAGES];
   logic       bclk_d_q;
   logic       bclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) begin
            chain_q[i] <= '0;
         end
         bclk_d_q <= 1'b0;
      end else begin
         chain_q[0] <= {bclk_in, fs_in, din};
         for (int i = 1; i < int'(STAGES); i++) begin
            chain_q[i] <= chain_q[i-1];
         end
         bclk_d_q <= chain_q[STAGES-1][2];
      end
   end

   assign bclk_s      = chain_q[STAGES-1][2];
   assign fs_s        = chain_q[STAGES-1][1];
   assign din_s       = chain_q[STAGES-1][0];
   assign edge_o.rise = bclk_s & ~bclk_d_q;
   assign edge_o.fall = ~bclk_s & bclk_d_q;

endmodule

// File: rtl/pcm_serdes.sv
module pcm_serdes
   import pcm_port_pkg::*;
#(
   parameter int unsigned    SAMPLE_W = 8,
   parameter logic [SAMPLE_W-1:0] TX_IDLE = 8'hD5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  bit_edge_t           edge_i,
   input  logic                fs_i,
   input  logic                din_i,
   input  logic [SAMPLE_W-1:0] tx_data,
   input  logic                tx_valid,
   output logic                tx_ready,
   output logic [SAMPLE_W-1:0] rx_data,
   output logic                rx_valid,
   output logic                dout
);
   localparam int unsigned PW = $clog2(SAMPLE_W + 1);

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("pcm_serdes: SAMPLE_W must be at least 2");
   end

   logic [SAMPLE_W-1:0] hold_q;
   logic [SAMPLE_W-1:0] tx_sh_q;
   logic [SAMPLE_W-2:0] rx_sh_q;
   logic [PW-1:0]       pos_q;   // index of the sample bit in flight, SAMPLE_W = idle
   logic                live_q;  // current bit period carries a sample bit
   logic                load;

   assign load     = edge_i.fall && fs_i;
   assign tx_ready = !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= TX_IDLE;
         tx_sh_q  <= TX_IDLE;
         rx_sh_q  <= '0;
         pos_q    <= PW'(SAMPLE_W);
         live_q   <= 1'b0;
         dout     <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (tx_valid && tx_ready) begin
            hold_q <= tx_data;
         end
         if (edge_i.rise) begin
            if (pos_q < PW'(SAMPLE_W)) begin
               dout    <= tx_sh_q[SAMPLE_W-1];
               tx_sh_q <= {tx_sh_q[SAMPLE_W-2:0], 1'b0};
               live_q  <= 1'b1;
            end else begin
               dout   <= 1'b0;
               live_q <= 1'b0;
            end
         end
         if (edge_i.fall) begin
            if (fs_i) begin
               pos_q   <= '0;
               tx_sh_q <= hold_q;
               live_q  <= 1'b0;
            end else if (live_q) begin
               rx_sh_q <= {rx_sh_q[SAMPLE_W-3:0], din_i};
               pos_q   <= pos_q + 1'b1;
               live_q  <= 1'b0;
               if (pos_q == PW'(SAMPLE_W - 1)) begin
                  rx_data  <= {rx_sh_q, din_i};
                  rx_valid <= 1'b1;
               end
            end
         end
      end
   end

   p_dout_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> $past(edge_i.rise));

   p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_load_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(edge_i.fall && fs_i) |-> (tx_sh_q == $past(hold_q)));

   p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(edge_i.rise) && ($past(pos_q) == PW'(SAMPLE_W))) |-> !dout);

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
   import pcm_port_pkg::*;
#(
   parameter int unsigned          SAMPLE_W    = 8,
   parameter int unsigned          FRAME_BITS  = 256,
   parameter int unsigned          WORK_KHZ    = 98304,
   parameter int unsigned          BIT_KHZ     = 2048,
   parameter int unsigned          SYNC_STAGES = 2,
   parameter logic [SAMPLE_W-1:0]  TX_IDLE     = 8'hD5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                int_mode,
   input  logic                bclk_in,
   input  logic                fs_in,
   input  logic                pcmin,
   input  logic [SAMPLE_W-1:0] tx_data,
   input  logic                tx_valid,
   output logic                tx_ready,
   output logic [SAMPLE_W-1:0] rx_data,
   output logic                rx_valid,
   output logic                pcmout,
   output logic                bclk_out,
   output logic                fs_out,
   output logic                clk_drive_en,
   output logic                int_refused
);
   localparam bit          INT_OK  = (WORK_KHZ == REQ_WORK_KHZ);
   localparam int unsigned CLK_DIV = WORK_KHZ / BIT_KHZ;

   if (FRAME_BITS <= SAMPLE_W) begin : g_bad_frame
      $error("pcm_voice_port: FRAME_BITS must exceed SAMPLE_W");
   end
   if (INT_OK && ((WORK_KHZ % BIT_KHZ) != 0 || (CLK_DIV % 2) != 0)) begin : g_bad_ratio
      $error("pcm_voice_port: working clock must be an even multiple of the bit clock");
   end

   clk_src_e  src;
   logic      eff_int;
   logic      gen_bclk, gen_fs;
   bit_edge_t gen_edge, ext_edge, sel_edge;
   logic      ext_fs, din_s, sel_fs;

   if (INT_OK) begin : g_gen
      assign eff_int     = int_mode;
      assign int_refused = 1'b0;
      pcm_clk_gen #(
         .CLK_DIV    (CLK_DIV),
         .FRAME_BITS (FRAME_BITS)
      ) u_gen (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (eff_int),
         .bclk   (gen_bclk),
         .fs     (gen_fs),
         .edge_o (gen_edge)
      );
   end else begin : g_no_gen
      assign eff_int     = 1'b0;
      assign int_refused = int_mode;
      assign gen_bclk    = 1'b0;
      assign gen_fs      = 1'b0;
      assign gen_edge    = '0;
   end

   pcm_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_in (bclk_in),
      .fs_in   (fs_in),
      .din     (pcmin),
      .edge_o  (ext_edge),
      .fs_s    (ext_fs),
      .din_s   (din_s)
   );

   assign src      = eff_int ? SRC_INTERNAL : SRC_EXTERNAL;
   assign sel_edge = (src == SRC_INTERNAL) ? gen_edge : ext_edge;
   assign sel_fs   = (src == SRC_INTERNAL) ? gen_fs   : ext_fs;

   assign clk_drive_en = eff_int;
   assign bclk_out     = gen_bclk & eff_int;
   assign fs_out       = gen_fs & eff_int;

   pcm_serdes #(
      .SAMPLE_W (SAMPLE_W),
      .TX_IDLE  (TX_IDLE)
   ) u_serdes (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_i   (sel_edge),
      .fs_i     (sel_fs),
      .din_i    (din_s),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .dout     (pcmout)
   );

   p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && !clk_drive_en) |-> int_refused);

   p_ext_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !int_mode |=> (!bclk_out || $past(int_mode) || int_mode));

endmodule

// File: tb/sim_pcm_voice_port.sv
module sim_pcm_voice_port;
   localparam int HP = 6;   // external bit clock half period in working cycles

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n, int_mode, bclk_in, fs_in, pcmin_ext, pcmin_int, use_int_codec, tx_valid;
   logic [7:0] tx_data;
   logic       pcmin;
   assign pcmin = use_int_codec ? pcmin_int : pcmin_ext;

   logic       tx_ready, rx_valid, pcmout, bclk_out, fs_out, clk_drive_en, int_refused;
   logic [7:0] rx_data;
   logic       tx_ready_b, rx_valid_b, pcmout_b, bclk_out_b, fs_out_b, clk_drive_en_b, int_refused_b;
   logic [7:0] rx_data_b;

   pcm_voice_port u0 (
      .clk(clk), .rst_n(rst_n), .int_mode(int_mode), .bclk_in(bclk_in), .fs_in(fs_in),
      .pcmin(pcmin), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .pcmout(pcmout), .bclk_out(bclk_out),
      .fs_out(fs_out), .clk_drive_en(clk_drive_en), .int_refused(int_refused)
   );

   pcm_voice_port #(.WORK_KHZ(100000)) u1 (
      .clk(clk), .rst_n(rst_n), .int_mode(int_mode), .bclk_in(bclk_in), .fs_in(fs_in),
      .pcmin(pcmin), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready_b),
      .rx_data(rx_data_b), .rx_valid(rx_valid_b), .pcmout(pcmout_b), .bclk_out(bclk_out_b),
      .fs_out(fs_out_b), .clk_drive_en(clk_drive_en_b), .int_refused(int_refused_b)
   );

   int     checks = 0;
   int     fails  = 0;
   longint cyc    = 0;
   bit     done   = 0;

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      if (!done && cyc > 150000) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         report();
      end
   end

   // Receive strobe monitors.
   int         rx_cnt = 0, rx_cnt_b = 0, rx_wide = 0;
   logic [7:0] last_rx = 8'h00, last_rx_b = 8'h00;
   logic       rxv_prev = 1'b0;
   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt++;
         last_rx = rx_data;
         if (rxv_prev) rx_wide++;
      end
      if (rx_valid_b) begin
         rx_cnt_b++;
         last_rx_b = rx_data_b;
      end
      rxv_prev = rx_valid;
   end

   // Internal-mode codec model and timing monitor for u0.
   logic       bprev = 1'b0, fprev = 1'b0, rose, fell;
   int         slot = 999;
   longint     last_edge = 0;
   bit         edge_valid = 0, have_fs = 0;
   int         len, hi_min, hi_max, lo_min, lo_max;
   int         bits_since_fs = 0, frame_min, frame_max, fs_rises = 0;
   int         fs_off_edge, fs_wide, int_idle_bad;
   int         meas_epoch = 0, seen_epoch = -1;
   logic [7:0] int_rx = 8'h00, int_seen = 8'h00;

   always @(negedge clk) begin
      if (seen_epoch != meas_epoch) begin
         seen_epoch   = meas_epoch;
         hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0;
         frame_min = 1000000; frame_max = 0;
         fs_off_edge = 0; fs_wide = 0; int_idle_bad = 0;
         edge_valid = 0; have_fs = 0;
      end
      rose = bclk_out && !bprev;
      fell = !bclk_out && bprev;
      if (rose || fell) begin
         if (edge_valid) begin
            len = int'(cyc - last_edge);
            if (rose) begin
               if (len < lo_min) lo_min = len;
               if (len > lo_max) lo_max = len;
            end else begin
               if (len < hi_min) hi_min = len;
               if (len > hi_max) hi_max = len;
            end
         end
         last_edge  = cyc;
         edge_valid = 1;
      end
      if ((fs_out != fprev) && !rose) fs_off_edge++;
      if (rose) begin
         bits_since_fs++;
         if (fs_out && fprev) fs_wide++;
         if (fs_out) begin
            if (have_fs) begin
               if (bits_since_fs < frame_min) frame_min = bits_since_fs;
               if (bits_since_fs > frame_max) frame_max = bits_since_fs;
            end
            have_fs       = 1;
            bits_since_fs = 0;
            slot          = 0;
            fs_rises++;
         end else begin
            slot++;
         end
         pcmin_int = (slot >= 1 && slot <= 8) ? int_rx[8-slot] : 1'b0;
      end
      if (fell) begin
         if (slot >= 1 && slot <= 8) int_seen[8-slot] = pcmout;
         else if (pcmout) int_idle_bad++;
      end
      bprev = bclk_out;
      fprev = fs_out;
   end

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      while (!(tx_ready && tx_ready_b)) @(negedge clk);
      tx_data  = b;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   // External codec: bit 0 carries sync, bits 1..8 carry the sample.
   task automatic ext_frame(input logic [7:0] rxb, input int nbits,
                            output logic [7:0] seen, output logic [7:0] seen_b,
                            output int idle_bad, output int idle_bad_b);
      idle_bad   = 0;
      idle_bad_b = 0;
      seen       = 8'h00;
      seen_b     = 8'h00;
      for (int s = 0; s < nbits; s++) begin
         @(negedge clk);
         bclk_in   = 1'b1;
         fs_in     = (s == 0);
         pcmin_ext = (s >= 1 && s <= 8) ? rxb[8-s] : 1'b0;
         repeat (HP - 1) @(negedge clk);
         if (s >= 1 && s <= 8) begin
            seen[8-s]   = pcmout;
            seen_b[8-s] = pcmout_b;
         end else begin
            if (pcmout)   idle_bad++;
            if (pcmout_b) idle_bad_b++;
         end
         @(negedge clk);
         bclk_in = 1'b0;
         repeat (HP - 1) @(negedge clk);
      end
      fs_in = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic int_frame(input logic [7:0] txb, input logic [7:0] rxb);
      int n;
      int rc;
      push(txb);
      int_rx = rxb;
      rc = rx_cnt;
      n  = fs_rises;
      while (fs_rises == n) @(negedge clk);
      while (slot < 10) @(negedge clk);
      chk(int_seen == txb, "R3 internal pcmout byte", int_seen, txb);
      chk(last_rx == rxb && rx_cnt == rc + 1, "R4 internal received byte", last_rx, rxb);
   endtask

   // Stimulus table: {byte to transmit, byte the codec sends}.
   localparam logic [15:0] VEC [6] = '{
      16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h80_01, 16'h01_80, 16'h5A_C3
   };

   logic [7:0] seen, seen_b;
   int         ib, ibb, rc, rcb;

   initial begin
      rst_n = 1'b0; int_mode = 1'b0; bclk_in = 1'b0; fs_in = 1'b0;
      pcmin_ext = 1'b0; use_int_codec = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
      repeat (5) @(negedge clk);

      // R9: reset state
      chk(bclk_out == 1'b0,     "R9 bclk_out in reset", bclk_out, 0);
      chk(fs_out == 1'b0,       "R9 fs_out in reset", fs_out, 0);
      chk(pcmout == 1'b0,       "R9 pcmout in reset", pcmout, 0);
      chk(rx_valid == 1'b0,     "R9 rx_valid in reset", rx_valid, 0);
      chk(clk_drive_en == 1'b0, "R9 clk_drive_en in reset", clk_drive_en, 0);
      chk(tx_ready == 1'b1,     "R9 tx_ready in reset", tx_ready, 1);

      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R5: idle byte before any transmit byte is accepted
      ext_frame(8'h3C, 11, seen, seen_b, ib, ibb);
      chk(seen == 8'hD5, "R5 idle byte after reset", seen, 8'hD5);
      chk(last_rx == 8'h3C, "R4 first received byte", last_rx, 8'h3C);
      // R7: external mode drives no timing
      chk(clk_drive_en == 1'b0 && bclk_out == 1'b0 && fs_out == 1'b0,
          "R7 no generated timing in external mode", {clk_drive_en, bclk_out, fs_out}, 0);

      foreach (VEC[i]) begin
         rc = rx_cnt;
         push(VEC[i][15:8]);
         ext_frame(VEC[i][7:0], 11, seen, seen_b, ib, ibb);
         chk(seen == VEC[i][15:8], "R3 external pcmout byte", seen, VEC[i][15:8]);
         chk(last_rx == VEC[i][7:0] && rx_cnt == rc + 1, "R4 external received byte", last_rx, VEC[i][7:0]);
         chk(ib == 0, "R6 pcmout idle outside sample", ib, 0);
         chk(seen_b == VEC[i][15:8], "R7 second instance follows external timing", seen_b, VEC[i][15:8]);
      end

      // R5: no new byte -> previous byte again
      ext_frame(8'h77, 11, seen, seen_b, ib, ibb);
      chk(seen == 8'h5A, "R5 previous byte repeated", seen, 8'h5A);
      chk(rx_wide == 0, "R4 rx_valid single cycle", rx_wide, 0);

      // Internal mode
      use_int_codec = 1'b1;
      meas_epoch++;
      @(negedge clk);
      int_mode = 1'b1;
      int_frame(8'hC6, 8'h39);
      int_frame(8'h81, 8'h7E);
      int_frame(8'h2B, 8'hD4);
      chk(clk_drive_en == 1'b1, "R1 drive enable in internal mode", clk_drive_en, 1);
      chk(hi_min == 24 && hi_max == 24, "R1 bit clock high phase", hi_max, 24);
      chk(lo_min == 24 && lo_max == 24, "R1 bit clock low phase", lo_max, 24);
      chk(frame_min == 256 && frame_max == 256, "R2 bit clocks per frame", frame_max, 256);
      chk(fs_wide == 0, "R2 frame sync one bit wide", fs_wide, 0);
      chk(fs_off_edge == 0, "R2 frame sync changes on rising bit clock", fs_off_edge, 0);
      chk(int_idle_bad == 0, "R6 internal pcmout idle outside sample", int_idle_bad, 0);
      chk(int_refused == 1'b0, "R8 allowed instance not refused", int_refused, 0);

      // R8: refused instance keeps working from external timing
      chk(int_refused_b == 1'b1, "R8 refusal flagged", int_refused_b, 1);
      chk(clk_drive_en_b == 1'b0 && bclk_out_b == 1'b0, "R8 refused instance drives no clock",
          {clk_drive_en_b, bclk_out_b}, 0);
      use_int_codec = 1'b0;
      rcb = rx_cnt_b;
      push(8'h96);
      ext_frame(8'h69, 11, seen, seen_b, ib, ibb);
      chk(seen_b == 8'h96, "R8 refused instance transmits", seen_b, 8'h96);
      chk(last_rx_b == 8'h69 && rx_cnt_b == rcb + 1, "R8 refused instance receives", last_rx_b, 8'h69);
      chk(ibb == 0, "R6 refused instance idle outside sample", ibb, 0);

      done = 1;
      report();
   end

endmodule